// File: doc/BRIEF.md
# CAM Control Register Port with Select/Acknowledge Handshake

This block is the host-facing control port of a content-addressable match engine. A host that runs on no shared clock addresses one of a few 16-bit registers with a 3-bit address and a write-enable. It raises a select strobe and then holds every signal steady until the port raises an acknowledge. The port brings select, write-enable and address into its own clock domain through a flop chain. It performs exactly one read or write per select assertion, and it keeps acknowledge raised until the host lets go of select.

Four registers are mapped. The flag register has two read-only status positions. Bit 10 is operation-complete and bit 4 is entry-queue-empty, and both follow the engine's status inputs. The port also drives a check-ready output that the engine uses to tell when a check-for-value command would give a valid answer. The error and almost-full registers are plain storage with nonzero reset values. A write to the command register hands the word to the engine with a one-cycle strobe.

Top module: `camport_top`

## Requirements
- R1: After reset, reads return 0x001C from the flag register (address 0, with queue-empty input 1 and done input 0), 0xFFFF from the error register (address 1), 0x3FFF from the almost-full register (address 2) and 0x0000 from the command register (address 3).
- R2: With write-enable high, a transfer returns the addressed register on the data output. With write-enable low, it stores the data input into the addressed register.
- R3: Acknowledge goes high on the fourth rising clock edge after select is raised: two edges in the synchroniser and two in the handshake.
- R4: Acknowledge stays high for as long as select is held. It goes low on the third rising edge after select is dropped.
- R5: Holding select high long after acknowledge performs only one transfer. A further transfer starts only after acknowledge has gone low and select rises again.
- R6: Addresses 4 to 7 read as zero, and writes to them change no mapped register.
- R7: Flag bits 10 (operation-complete) and 4 (queue-empty) always read the engine status inputs, and writes to them are ignored. All other flag bits are writable and read back as written.
- R8: Check-ready is high one clock after both status inputs are high, and low one clock after either of them is low.
- R9: A write to the command register sets the command word output to the written data and pulses the command strobe for exactly one cycle.
- R10: Data-output-enable is high only while acknowledge is high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_sel | input | 1 | Host select strobe, asynchronous |
| hst_we | input | 1 | High = read, low = write |
| hst_addr | input | 3 | Register address |
| hst_din | input | 16 | Write data from host |
| hst_dout | output | 16 | Read data to host |
| hst_dout_en | output | 1 | Host bus should be driven with read data |
| hst_ack | output | 1 | Transfer acknowledge |
| eng_done | input | 1 | Engine last operation complete |
| eng_qempty | input | 1 | Engine entry queue empty |
| eng_chk_ready | output | 1 | Both status conditions met |
| cmd_word | output | 16 | Last command written |
| cmd_strobe | output | 1 | One-cycle pulse on command write |

## Verification
Inputs change on falling edges, and the bench counts the falling edges that pass until acknowledge changes. Acknowledge must appear after exactly four edges once select rises, and must clear after exactly three once select falls. Read data, command word and data-enable are sampled while acknowledge is high, because they are latched on the edge that raises acknowledge. Check-ready is sampled on the falling edge one clock after the status inputs change. Command strobes are counted on every falling edge, which confirms one pulse per command write even when select is held long.

// File: rtl/camport_pkg.sv
// Package: shared constants and the handshake state type for the control port.
// Assumes a 3-bit address space with four mapped registers.
package camport_pkg;
    typedef enum logic [1:0] {HS_IDLE, HS_WAIT, HS_ACK} hs_state_t;
    localparam int FLAG_DONE_BIT   = 10;
    localparam int FLAG_QEMPTY_BIT = 4;
    localparam logic [2:0] ADR_FLAG = 3'd0;
    localparam logic [2:0] ADR_ERR  = 3'd1;
    localparam logic [2:0] ADR_AFUL = 3'd2;
    localparam logic [2:0] ADR_CMD  = 3'd3;
endpackage

// File: rtl/camport_sync.sv
// Module: multi-stage flop chain that brings W asynchronous bits into clk.
// Assumes the bits are held stable by the sender long enough to pass the chain.
module camport_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Shift one stage of the chain, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= '0;
                else if (i == 0) chain[i] <= d;
                else chain[i] <= chain[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/camport_hs.sv
// Module: select/acknowledge handshake sequencer.
// Assumes synchronised select and write-enable that stay stable until acknowledge.
// One transfer per select assertion: the access fires one cycle before acknowledge rises.
module camport_hs
    import camport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic we_s,
    output logic ack,
    output logic wr_pulse,
    output logic rd_pulse
);
    hs_state_t state, nxt;

    // Next-state choice for the handshake.
    always_comb begin
        nxt = state;
        case (state)
            HS_IDLE: if (sel_s) nxt = HS_WAIT;
            HS_WAIT: nxt = HS_ACK;
            HS_ACK:  if (!sel_s) nxt = HS_IDLE;
            default: nxt = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HS_IDLE;
        else state <= nxt;
    end

    assign ack      = (state == HS_ACK);
    assign wr_pulse = (state == HS_WAIT) && !we_s;
    assign rd_pulse = (state == HS_WAIT) && we_s;

    // R3
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> (sel_s && $past(sel_s)));
    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && sel_s) |=> ack);
    // R4
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !sel_s) |=> !ack);
    // R5
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse || rd_pulse) |=> !(wr_pulse || rd_pulse));
endmodule

// File: rtl/camport_regs.sv
// Module: register file for flag, error, almost-full and command registers.
// Flag status bits are read-only and come from the engine inputs; unmapped reads give zero.
module camport_regs
    import camport_pkg::*;
#(
    parameter int          AW       = 3,
    parameter int          DW       = 16,
    parameter logic [15:0] FLAG_RST = 16'h001C,
    parameter logic [15:0] ERR_RST  = 16'hFFFF,
    parameter logic [15:0] AFUL_RST = 16'h3FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    input  logic          done_in,
    input  logic          qempty_in,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] cmd_word,
    output logic          cmd_strobe,
    output logic          chk_ready
);
    localparam logic [DW-1:0] RO_MASK  = (DW'(1) << FLAG_DONE_BIT) | (DW'(1) << FLAG_QEMPTY_BIT);
    localparam logic [DW-1:0] RW_MASK  = ~RO_MASK;
    localparam logic [DW-1:0] FLAG_INI = DW'(FLAG_RST) & RW_MASK;

    logic [DW-1:0] flag_q, err_q, aful_q, cmd_q, flag_view, rd_mux;

    // Status bits overlaid on the writable flag bits.
    always_comb begin
        flag_view = flag_q & RW_MASK;
        flag_view[FLAG_DONE_BIT]   = done_in;
        flag_view[FLAG_QEMPTY_BIT] = qempty_in;
    end

    // Read selection by address; unmapped slots read zero.
    always_comb begin
        case (addr)
            AW'(ADR_FLAG): rd_mux = flag_view;
            AW'(ADR_ERR):  rd_mux = err_q;
            AW'(ADR_AFUL): rd_mux = aful_q;
            AW'(ADR_CMD):  rd_mux = cmd_q;
            default:       rd_mux = '0;
        endcase
    end

    // Register writes, read-data capture and command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q     <= FLAG_INI;
            err_q      <= DW'(ERR_RST);
            aful_q     <= DW'(AFUL_RST);
            cmd_q      <= '0;
            rdata      <= '0;
            cmd_strobe <= 1'b0;
        end else begin
            cmd_strobe <= 1'b0;
            if (rd) rdata <= rd_mux;
            if (wr) begin
                case (addr)
                    AW'(ADR_FLAG): flag_q <= wdata & RW_MASK;
                    AW'(ADR_ERR):  err_q  <= wdata;
                    AW'(ADR_AFUL): aful_q <= wdata;
                    AW'(ADR_CMD):  begin cmd_q <= wdata; cmd_strobe <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

    // Registered check-ready from the two status conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_ready <= 1'b0;
        else chk_ready <= done_in && qempty_in;
    end

    assign cmd_word = cmd_q;

    // R9
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);
    // R7
    flag_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == AW'(ADR_FLAG)) |=> ((flag_q & RO_MASK) == '0));
    // R8
    chk_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ready |-> $past(done_in && qempty_in));
endmodule

// File: rtl/camport_top.sv
// Module: CAM control port top. Synchronises the host strobes, runs the
// select/acknowledge handshake and hosts the register file.
// Assumes the host holds address, write-enable, data and select until acknowledge.
module camport_top
    import camport_pkg::*;
#(
    parameter int          ADDR_W   = 3,
    parameter int          DATA_W   = 16,
    parameter int          SYNC_N   = 2,
    parameter logic [15:0] FLAG_RST = 16'h001C,
    parameter logic [15:0] ERR_RST  = 16'hFFFF,
    parameter logic [15:0] AFUL_RST = 16'h3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_sel,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [DATA_W-1:0] hst_din,
    output logic [DATA_W-1:0] hst_dout,
    output logic              hst_dout_en,
    output logic              hst_ack,
    input  logic              eng_done,
    input  logic              eng_qempty,
    output logic              eng_chk_ready,
    output logic [DATA_W-1:0] cmd_word,
    output logic              cmd_strobe
);
    localparam int SW = ADDR_W + 2;

    logic [SW-1:0]     sync_out;
    logic              sel_s, we_s, wr_p, rd_p;
    logic [ADDR_W-1:0] addr_s;

    camport_sync #(.W(SW), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({hst_sel, hst_we, hst_addr}), .q(sync_out)
    );

    assign {sel_s, we_s, addr_s} = sync_out;

    camport_hs u_hs (
        .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .we_s(we_s),
        .ack(hst_ack), .wr_pulse(wr_p), .rd_pulse(rd_p)
    );

    camport_regs #(
        .AW(ADDR_W), .DW(DATA_W),
        .FLAG_RST(FLAG_RST), .ERR_RST(ERR_RST), .AFUL_RST(AFUL_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr_s), .wdata(hst_din),
        .wr(wr_p), .rd(rd_p), .done_in(eng_done), .qempty_in(eng_qempty),
        .rdata(hst_dout), .cmd_word(cmd_word), .cmd_strobe(cmd_strobe),
        .chk_ready(eng_chk_ready)
    );

    assign hst_dout_en = hst_ack && we_s;

    // R10
    dout_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_dout_en |-> (hst_ack && hst_we));
endmodule

// File: tb/camport_top_test.sv
module camport_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b1, done = 1'b0, qempty = 1'b1;
    logic [2:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout, cmdw;
    logic        dout_en, ack, chk_rdy, cmd_stb;
    int          checks = 0, fails = 0, strobes = 0, cyc = 0;
    int          up_lat, dn_lat;
    logic        en_seen;
    logic [15:0] rd_val;

    always #5 clk = ~clk;

    camport_top uut (
        .clk(clk), .rst_n(rst_n), .hst_sel(sel), .hst_we(we), .hst_addr(addr),
        .hst_din(din), .hst_dout(dout), .hst_dout_en(dout_en), .hst_ack(ack),
        .eng_done(done), .eng_qempty(qempty), .eng_chk_ready(chk_rdy),
        .cmd_word(cmdw), .cmd_strobe(cmd_stb)
    );

    // Count command strobes and watch for a hung run.
    always @(negedge clk) begin
        if (cmd_stb) strobes++;
        cyc++;
        if (cyc > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles, expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One full transfer; hold counts extra negedges of select after acknowledge.
    task automatic xfer(input logic w, input logic [2:0] a, input logic [15:0] d, input int hold);
        @(negedge clk);
        we = w; addr = a; din = d; sel = 1'b1;
        up_lat = 0;
        do begin @(negedge clk); up_lat++; end while (!ack && up_lat < 20);
        rd_val = dout; en_seen = dout_en;
        for (int k = 0; k < hold; k++) @(negedge clk);
        sel = 1'b0;
        dn_lat = 0;
        do begin @(negedge clk); dn_lat++; end while (ack && dn_lat < 20);
    endtask

    // {we, addr, data, expected read}
    localparam logic [35:0] VEC [14] = '{
        {1'b0, 3'd1, 16'h1234, 16'h0000},
        {1'b1, 3'd1, 16'h0000, 16'h1234},
        {1'b0, 3'd2, 16'h0100, 16'h0000},
        {1'b1, 3'd2, 16'h0000, 16'h0100},
        {1'b0, 3'd0, 16'hFFFF, 16'h0000},
        {1'b1, 3'd0, 16'h0000, 16'hFBFF},
        {1'b0, 3'd0, 16'h0000, 16'h0000},
        {1'b1, 3'd0, 16'h0000, 16'h0010},
        {1'b0, 3'd5, 16'hAAAA, 16'h0000},
        {1'b1, 3'd5, 16'h0000, 16'h0000},
        {1'b1, 3'd1, 16'h0000, 16'h1234},
        {1'b1, 3'd2, 16'h0000, 16'h0100},
        {1'b0, 3'd3, 16'h0042, 16'h0000},
        {1'b1, 3'd3, 16'h0000, 16'h0042}
    };

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ack idle", ack, 0);
        check("R1 strobe idle", cmd_stb, 0);
        xfer(1, 3'd0, 0, 0); check("R1 flag", rd_val, 16'h001C);
        check("R3 ack latency", up_lat, 4);
        check("R4 drop latency", dn_lat, 3);
        check("R10 enable on read", en_seen, 1);
        xfer(1, 3'd1, 0, 0); check("R1 error", rd_val, 16'hFFFF);
        xfer(1, 3'd2, 0, 0); check("R1 almost-full", rd_val, 16'h3FFF);
        xfer(1, 3'd3, 0, 0); check("R1 command", rd_val, 16'h0000);

        // R2 R6 R7 vector walk
        for (int i = 0; i < 14; i++) begin
            xfer(VEC[i][35], VEC[i][34:32], VEC[i][31:16], 0);
            if (VEC[i][35]) check("R2/R6/R7 read vector", rd_val, VEC[i][15:0]);
            else check("R10 no enable on write", en_seen, 0);
        end
        check("R9 command word", cmdw, 16'h0042);
        check("R9 one strobe", strobes, 1);

        // R5 R4: long hold, single command write
        s0 = strobes;
        xfer(0, 3'd3, 16'h5A5A, 12);
        check("R4 ack held", dn_lat, 3);
        check("R5 single transfer", strobes - s0, 1);
        check("R9 word after hold", cmdw, 16'h5A5A);

        // R7 R8 status bits
        @(negedge clk); done = 1'b1; qempty = 1'b0;
        @(negedge clk); check("R8 only done", chk_rdy, 0);
        qempty = 1'b1;
        @(negedge clk); check("R8 both set", chk_rdy, 1);
        xfer(1, 3'd0, 0, 0); check("R7 flag status", rd_val, 16'h0410);
        done = 1'b0;
        @(negedge clk); check("R8 cleared", chk_rdy, 0);

        // R1 reset restores values
        @(negedge clk); rst_n = 1'b0; qempty = 1'b1;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        xfer(1, 3'd0, 0, 0); check("R1 flag after reset", rd_val, 16'h001C);
        xfer(1, 3'd1, 0, 0); check("R1 error after reset", rd_val, 16'hFFFF);
        xfer(1, 3'd2, 0, 0); check("R1 almost-full after reset", rd_val, 16'h3FFF);
        xfer(1, 3'd3, 0, 0); check("R1 command after reset", rd_val, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule